// File: doc/BRIEF.md
# Two-Phase Stepper Winding Current Regulator

This block closes the current loop of a two-phase stepper motor in logic, one loop per winding. On every sample strobe each loop takes the winding current setpoint from an external microstep sequencer and the measured winding current. It updates a discrete proportional-integral law and turns the signed result into a direction bit and a pulse-width duty for one full-bridge. Because the strobe rate is set from outside, the same logic serves a 40 kHz loop or an 80 kHz one.

An over-current guard sits beside each loop. When the measured magnitude goes above a programmable limit, the bridge pulse is cut for the rest of the sampling period and the integrator holds its value. Two capture memories, one per winding, record the setpoint, the measurement and the new controller output at each strobe after a start trigger. They are read back later through an address/data port. The two loops can be driven with half-step setpoint patterns, and each winding's loop runs without regard to the other.

Top module: `stepper_current_loop`

## Requirements
- R1: At each strobe the error is e = sp - meas (signed). The proportional term is floor(Kp·e / 2^FRAC) and the integrator increment is floor(Ki·e / 2^FRAC), with Kp and Ki unsigned. The output u is the proportional term plus the updated integrator.
- R2: The updated integrator is clamped to the range ±period, and u is saturated to the same range. Here period is the period input sampled at the strobe.
- R3: dir_o of a winding is 1 when u < 0. pwm_o is high for exactly |u| of the clock cycles that follow the strobe, and it starts one cycle after the strobe edge.
- R4: The PWM counter restarts at each strobe and counts against the period value latched at that strobe. Later changes to the period input do not alter the running period.
- R5: While |meas| > limit, pwm_o goes low from the next cycle. It stays low until the next strobe, even if the current falls back below the limit.
- R6: At a strobe where the limit is exceeded, or was exceeded at any point since the previous strobe, the integrator keeps its old value. The proportional term still applies.
- R7: The two winding loops are independent. Over-current, setpoint or measurement on one winding has no effect on the other winding's outputs.
- R8: A trigger pulse restarts capture at entry 0 of both memories. Each later strobe writes one entry per winding, laid out as {sp[W-1:0], meas[W-1:0], u[CW:0]} from MSB to LSB, with u in two's complement.
- R9: When TDEPTH entries have been written, capture stops, trc_full_o for that memory reads 1, and later strobes overwrite nothing.
- R10: trc_sel_i picks the memory (the winding index) and trc_addr_i picks the entry. The selected word appears on trc_data_o after the next clock edge.
- R11: After reset, pwm_o, dir_o and trc_full_o are 0, both integrators are 0, and nothing is captured until a trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Sample strobe, one cycle wide |
| kp_i | input | GW | Proportional gain, unsigned, scaled by 2^-FRAC |
| ki_i | input | GW | Integral gain, unsigned, scaled by 2^-FRAC |
| ilim_i | input | W | Current limit magnitude, unsigned |
| period_i | input | CW | PWM period and duty full scale, in clocks |
| sp_i | input | NPH×W | Signed current setpoint per winding |
| meas_i | input | NPH×W | Signed measured current per winding |
| pwm_o | output | NPH | Bridge pulse per winding |
| dir_o | output | NPH | Bridge direction per winding, 1 for negative drive |
| trc_trig_i | input | 1 | Capture start pulse |
| trc_sel_i | input | SW | Capture memory select |
| trc_addr_i | input | AW | Capture read address |
| trc_data_o | output | 2W+CW+1 | Capture read data |
| trc_full_o | output | NPH | Capture memory full, per winding |

## Verification
Some properties are checked on every cycle. The duty magnitude never exceeds the latched period. An over-current cycle is always followed by a low pulse output. The integrator stays inside ±period after an unfrozen strobe and does not move after a frozen one. A full capture memory stays full until the next trigger. The scenarios cover what no single-cycle property can show. They count the pulse width against the computed control law under random gains and currents, and they show that a period change made after the strobe is ignored. They also show that a mid-period over-current on one winding cuts only that winding's pulse and freezes its next update, and that the captured words match the strobe history and survive extra strobes once full.

// File: rtl/scl_pkg.sv
package scl_pkg;

  // Larger of two sizes, used for internal accumulator widths.
  function automatic int scl_max(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Index width for n items, at least one bit.
  function automatic int scl_idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/scl_ilim.sv
// Over-current comparator for one winding: flags |meas| > limit.
module scl_ilim #(
  parameter int W = 12
) (
  input  logic signed [W-1:0] meas_i,
  input  logic        [W-1:0] ilim_i,
  output logic                oc_o
);
  logic signed [W:0] m_ext;
  logic        [W:0] m_abs;

  always_comb begin
    m_ext = {meas_i[W-1], meas_i};
    m_abs = m_ext[W] ? (-m_ext) : m_ext;
    oc_o  = m_abs > {1'b0, ilim_i};
  end
endmodule

// File: rtl/scl_pi.sv
// Discrete PI law for one winding, evaluated on the sample strobe.
module scl_pi
  import scl_pkg::*;
#(
  parameter int W    = 12,
  parameter int GW   = 8,
  parameter int FRAC = 4,
  parameter int CW   = 13,
  localparam int ACC = scl_max(W + GW + 3, CW + 3)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick_i,
  input  logic                freeze_i,
  input  logic [GW-1:0]       kp_i,
  input  logic [GW-1:0]       ki_i,
  input  logic [CW-1:0]       period_i,
  input  logic signed [W-1:0] sp_i,
  input  logic signed [W-1:0] meas_i,
  output logic signed [CW:0]  u_nxt_o,
  output logic [CW-1:0]       mag_o,
  output logic                neg_o
);
  logic signed [ACC-1:0] integ_q;
  logic signed [ACC-1:0] e_x, kp_x, ki_x, lim_x;
  logic signed [ACC-1:0] p_t, i_inc, i_sum, i_cl, i_nxt, u_sum, u_s;

  always_comb begin
    e_x   = ACC'(sp_i) - ACC'(meas_i);
    kp_x  = ACC'({1'b0, kp_i});
    ki_x  = ACC'({1'b0, ki_i});
    lim_x = ACC'({1'b0, period_i});
    p_t   = (kp_x * e_x) >>> FRAC;
    i_inc = (ki_x * e_x) >>> FRAC;
    i_sum = integ_q + i_inc;
    if (i_sum > lim_x)       i_cl = lim_x;
    else if (i_sum < -lim_x) i_cl = -lim_x;
    else                     i_cl = i_sum;
    i_nxt = freeze_i ? integ_q : i_cl;
    u_sum = p_t + i_nxt;
    if (u_sum > lim_x)       u_s = lim_x;
    else if (u_sum < -lim_x) u_s = -lim_x;
    else                     u_s = u_sum;
    u_nxt_o = u_s[CW:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      integ_q <= '0;
      mag_o   <= '0;
      neg_o   <= 1'b0;
    end else if (tick_i) begin
      integ_q <= i_nxt;
      mag_o   <= CW'((u_s < 0) ? -u_s : u_s);
      neg_o   <= u_s[ACC-1];
    end
  end

  // R2: an unfrozen update leaves the integrator inside +/- period
  p_integ_bound_r2: assert property (@(posedge clk) disable iff (rst)
    (tick_i && !freeze_i) |=> (integ_q <= $past(lim_x) && integ_q >= -$past(lim_x)));

  // R6: a frozen update holds the integrator
  p_freeze_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (tick_i && freeze_i) |=> $stable(integ_q));
endmodule

// File: rtl/scl_pwm.sv
// Pulse generator for one bridge with over-current blanking.
module scl_pwm #(
  parameter int CW = 13
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_i,
  input  logic [CW-1:0] period_i,
  input  logic [CW-1:0] mag_i,
  input  logic          neg_i,
  input  logic          oc_i,
  output logic          pwm_o,
  output logic          dir_o,
  output logic          blk_o
);
  logic [CW-1:0] cnt_q, prd_q;
  logic          blk_q;
  logic          wrap;

  assign wrap  = ({1'b0, cnt_q} + (CW+1)'(1)) >= {1'b0, prd_q};
  assign blk_o = blk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      prd_q <= '0;
      blk_q <= 1'b0;
      pwm_o <= 1'b0;
      dir_o <= 1'b0;
    end else begin
      if (tick_i) begin
        cnt_q <= '0;
        prd_q <= period_i;
      end else if (wrap) begin
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
      blk_q <= oc_i | (blk_q & ~tick_i);
      pwm_o <= (cnt_q < mag_i) && !blk_q && !oc_i;
      dir_o <= neg_i;
    end
  end

  // R2: duty magnitude never exceeds the latched period
  p_duty_range_r2: assert property (@(posedge clk) disable iff (rst)
    mag_i <= prd_q);

  // R5: an over-current cycle forces the pulse low on the next cycle
  p_oc_blank_r5: assert property (@(posedge clk) disable iff (rst)
    oc_i |=> !pwm_o);
endmodule

// File: rtl/scl_trace.sv
// Capture memory: one entry per strobe after a trigger, stops when full.
module scl_trace
  import scl_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DW    = 38,
  localparam int AW   = scl_idx_w(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          trig_i,
  input  logic          tick_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o,
  output logic          full_o
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW:0]   ptr_q;
  logic          cap_q;
  logic          wr_en;

  assign wr_en  = tick_i && cap_q && !trig_i && (ptr_q < (AW+1)'(DEPTH));
  assign full_o = cap_q && (ptr_q == (AW+1)'(DEPTH));

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_q <= 1'b0;
      ptr_q <= '0;
    end else if (trig_i) begin
      cap_q <= 1'b1;
      ptr_q <= '0;
    end else if (wr_en) begin
      ptr_q <= ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[ptr_q[AW-1:0]] <= wdata_i;
    rdata_o <= mem[raddr_i];
  end

  // R9: a full memory stays full until the next trigger
  p_full_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (full_o && !trig_i) |=> full_o);
endmodule

// File: rtl/stepper_current_loop.sv
// Two-winding current regulator: PI loops, pulse generators, limiters, capture.
module stepper_current_loop
  import scl_pkg::*;
#(
  parameter int W      = 12,
  parameter int GW     = 8,
  parameter int FRAC   = 4,
  parameter int CW     = 13,
  parameter int TDEPTH = 16,
  parameter int NPH    = 2,
  localparam int AW    = scl_idx_w(TDEPTH),
  localparam int SW    = scl_idx_w(NPH),
  localparam int TW    = 2 * W + CW + 1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          tick_i,
  input  logic [GW-1:0]                 kp_i,
  input  logic [GW-1:0]                 ki_i,
  input  logic [W-1:0]                  ilim_i,
  input  logic [CW-1:0]                 period_i,
  input  logic signed [NPH-1:0][W-1:0]  sp_i,
  input  logic signed [NPH-1:0][W-1:0]  meas_i,
  output logic [NPH-1:0]                pwm_o,
  output logic [NPH-1:0]                dir_o,
  input  logic                          trc_trig_i,
  input  logic [SW-1:0]                 trc_sel_i,
  input  logic [AW-1:0]                 trc_addr_i,
  output logic [TW-1:0]                 trc_data_o,
  output logic [NPH-1:0]                trc_full_o
);
  logic [NPH-1:0]          oc_w, blk_w, neg_w;
  logic [NPH-1:0][CW-1:0]  mag_w;
  logic [NPH-1:0][CW:0]    unx_w;
  logic [TW-1:0]           rd_w [NPH];
  logic [SW-1:0]           sel_q;

  for (genvar p = 0; p < NPH; p++) begin : g_ph
    scl_ilim #(.W(W)) u_lim (
      .meas_i (meas_i[p]),
      .ilim_i (ilim_i),
      .oc_o   (oc_w[p])
    );

    scl_pi #(.W(W), .GW(GW), .FRAC(FRAC), .CW(CW)) u_pi (
      .clk      (clk),
      .rst      (rst),
      .tick_i   (tick_i),
      .freeze_i (oc_w[p] | blk_w[p]),
      .kp_i     (kp_i),
      .ki_i     (ki_i),
      .period_i (period_i),
      .sp_i     (sp_i[p]),
      .meas_i   (meas_i[p]),
      .u_nxt_o  (unx_w[p]),
      .mag_o    (mag_w[p]),
      .neg_o    (neg_w[p])
    );

    scl_pwm #(.CW(CW)) u_pwm (
      .clk      (clk),
      .rst      (rst),
      .tick_i   (tick_i),
      .period_i (period_i),
      .mag_i    (mag_w[p]),
      .neg_i    (neg_w[p]),
      .oc_i     (oc_w[p]),
      .pwm_o    (pwm_o[p]),
      .dir_o    (dir_o[p]),
      .blk_o    (blk_w[p])
    );

    scl_trace #(.DEPTH(TDEPTH), .DW(TW)) u_trc (
      .clk     (clk),
      .rst     (rst),
      .trig_i  (trc_trig_i),
      .tick_i  (tick_i),
      .wdata_i ({sp_i[p], meas_i[p], unx_w[p]}),
      .raddr_i (trc_addr_i),
      .rdata_o (rd_w[p]),
      .full_o  (trc_full_o[p])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) sel_q <= '0;
    else     sel_q <= trc_sel_i;
  end

  assign trc_data_o = rd_w[sel_q];
endmodule

// File: tb/tb_stepper_current_loop.sv
`timescale 1ns/1ps
module tb_stepper_current_loop;
  localparam int W = 12, GW = 8, FRAC = 4, CW = 13, DEPTH = 16, NPH = 2;
  localparam int P = 40;
  localparam int TW = 2 * W + CW + 1;
  localparam int AW = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic                         rst, tick_i, trc_trig_i;
  logic [GW-1:0]                kp_i, ki_i;
  logic [W-1:0]                 ilim_i;
  logic [CW-1:0]                period_i;
  logic signed [NPH-1:0][W-1:0] sp_i, meas_i;
  logic [NPH-1:0]               pwm_o, dir_o, trc_full_o;
  logic [0:0]                   trc_sel_i;
  logic [AW-1:0]                trc_addr_i;
  logic [TW-1:0]                trc_data_o;

  stepper_current_loop #(.W(W), .GW(GW), .FRAC(FRAC), .CW(CW), .TDEPTH(DEPTH), .NPH(NPH)) dut (
    .clk(clk), .rst(rst), .tick_i(tick_i), .kp_i(kp_i), .ki_i(ki_i), .ilim_i(ilim_i),
    .period_i(period_i), .sp_i(sp_i), .meas_i(meas_i), .pwm_o(pwm_o), .dir_o(dir_o),
    .trc_trig_i(trc_trig_i), .trc_sel_i(trc_sel_i), .trc_addr_i(trc_addr_i),
    .trc_data_o(trc_data_o), .trc_full_o(trc_full_o)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  longint integ_m [NPH];
  bit hit_m [NPH];
  logic [TW-1:0] tr_exp [NPH][DEPTH];
  int tr_ptr = 0;
  bit tr_cap = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint clampl(input longint v, input longint lim);
    if (v > lim) return lim;
    if (v < -lim) return -lim;
    return v;
  endfunction

  function automatic longint absl(input longint v);
    return (v < 0) ? -v : v;
  endfunction

  // One sampling period: strobe, then P sampled cycles.
  // ocv: mid-period over-current sample index per winding (-1 none); alt: period change after strobe.
  task automatic run_period(input int oc0, input int oc1, input int alt, input string tag);
    longint u_m [NPH];
    bit over [NPH];
    int hi [NPH];
    int ocat [NPH];
    logic signed [W-1:0] keep [NPH];
    longint e, pt, ii, inew, lim;
    ocat[0] = oc0; ocat[1] = oc1;
    lim = longint'(period_i);
    for (int p = 0; p < NPH; p++) begin
      e = longint'($signed(sp_i[p])) - longint'($signed(meas_i[p]));
      over[p] = absl(longint'($signed(meas_i[p]))) > longint'(ilim_i);
      pt = (longint'(kp_i) * e) >>> FRAC;
      ii = (longint'(ki_i) * e) >>> FRAC;
      inew = (hit_m[p] || over[p]) ? integ_m[p] : clampl(integ_m[p] + ii, lim);
      u_m[p] = clampl(pt + inew, lim);
      integ_m[p] = inew;
      hit_m[p] = over[p] || (ocat[p] >= 0);
      if (tr_cap && tr_ptr < DEPTH)
        tr_exp[p][tr_ptr] = {sp_i[p], meas_i[p], (CW+1)'(u_m[p])};
      hi[p] = 0;
      keep[p] = meas_i[p];
    end
    if (tr_cap && tr_ptr < DEPTH) tr_ptr++;
    tick_i = 1'b1;
    @(posedge clk); @(negedge clk);
    tick_i = 1'b0;
    if (alt > 0) period_i = CW'(alt);
    for (int k = 1; k <= P; k++) begin
      @(posedge clk); @(negedge clk);
      for (int p = 0; p < NPH; p++) begin
        if (k == 1)
          chk(dir_o[p] == (u_m[p] < 0), $sformatf("R3 dir ph%0d %s", p, tag), dir_o[p], u_m[p] < 0);
        if (pwm_o[p]) hi[p]++;
        if (k == ocat[p]) meas_i[p] = (p == 0) ? 12'sd1600 : -12'sd1600;
        if (k == ocat[p] + 1) meas_i[p] = keep[p];
      end
    end
    period_i = CW'(P);
    for (int p = 0; p < NPH; p++) begin
      longint expc;
      expc = absl(u_m[p]);
      if (over[p]) expc = 0;
      else if (ocat[p] >= 0 && ocat[p] < expc) expc = ocat[p];
      chk(hi[p] == expc, $sformatf("R3 width ph%0d %s", p, tag), hi[p], expc);
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1'b1; tick_i = 1'b0; trc_trig_i = 1'b0;
    kp_i = 8'd16; ki_i = 8'd0; ilim_i = 12'd1500; period_i = CW'(P);
    sp_i = '0; meas_i = '0; trc_sel_i = '0; trc_addr_i = '0;
    for (int p = 0; p < NPH; p++) begin integ_m[p] = 0; hit_m[p] = 0; end
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(pwm_o == '0, "R11 pwm at reset", pwm_o, 0);
    chk(dir_o == '0, "R11 dir at reset", dir_o, 0);
    chk(trc_full_o == '0, "R11 full at reset", trc_full_o, 0);
    rst = 1'b0;
    @(negedge clk);

    // R11: integrator starts at zero, so u equals the proportional term
    sp_i[0] = 12'sd7; sp_i[1] = -12'sd5;
    run_period(-1, -1, 0, "R11 zero integrator");

    // R1: random gains and currents
    for (int n = 0; n < 30; n++) begin
      kp_i = GW'($urandom_range(0, 63));
      ki_i = GW'($urandom_range(0, 31));
      for (int p = 0; p < NPH; p++) begin
        sp_i[p]   = W'($urandom_range(0, 1600)) - 12'sd800;
        meas_i[p] = W'($urandom_range(0, 1600)) - 12'sd800;
      end
      run_period(-1, -1, 0, "R1 random");
    end

    // R2: saturation and anti-windup, both signs
    kp_i = 8'd255; ki_i = 8'd31;
    sp_i[0] = 12'sd800; meas_i[0] = -12'sd800;
    sp_i[1] = -12'sd800; meas_i[1] = 12'sd800;
    repeat (3) run_period(-1, -1, 0, "R2 saturate");
    kp_i = 8'd2;
    sp_i[0] = -12'sd30; meas_i[0] = 12'sd0;
    sp_i[1] = 12'sd30; meas_i[1] = 12'sd0;
    repeat (3) run_period(-1, -1, 0, "R2 unwind");

    // R4: period changed after the strobe must not change the running period
    kp_i = 8'd16; ki_i = 8'd0;
    for (int p = 0; p < NPH; p++) begin
      meas_i[p] = '0;
      sp_i[p] = W'(((p == 0) ? 10 : -12) - integ_m[p]);
    end
    run_period(-1, -1, 5, "R4 period latch");

    // R5/R6/R7: over-current at the strobe on winding 0 only
    ki_i = 8'd31; kp_i = 8'd20;
    sp_i[0] = 12'sd100; meas_i[0] = 12'sd1600;
    sp_i[1] = 12'sd60;  meas_i[1] = 12'sd20;
    run_period(-1, -1, 0, "R5 R7 oc at strobe");
    meas_i[0] = 12'sd40;
    run_period(-1, -1, 0, "R6 frozen after oc");

    // R5/R6/R7: mid-period over-current on winding 1 (negative current)
    sp_i[0] = 12'sd50; meas_i[0] = 12'sd30;
    sp_i[1] = -12'sd80; meas_i[1] = -12'sd70;
    run_period(-1, 6, 0, "R5 R7 oc mid period");
    run_period(-1, -1, 0, "R6 frozen after mid oc");

    // R8/R9/R10: capture
    chk(trc_full_o == '0, "R9 not full before trigger", trc_full_o, 0);
    trc_trig_i = 1'b1;
    @(posedge clk); @(negedge clk);
    trc_trig_i = 1'b0;
    tr_cap = 1; tr_ptr = 0;
    for (int n = 0; n < DEPTH + 4; n++) begin
      kp_i = GW'($urandom_range(0, 63));
      ki_i = GW'($urandom_range(0, 31));
      for (int p = 0; p < NPH; p++) begin
        sp_i[p]   = W'($urandom_range(0, 1600)) - 12'sd800;
        meas_i[p] = W'($urandom_range(0, 1600)) - 12'sd800;
      end
      run_period(-1, -1, 0, "R8 capture run");
    end
    chk(trc_full_o == 2'b11, "R9 full flags", trc_full_o, 3);
    for (int p = 0; p < NPH; p++) begin
      for (int a = 0; a < DEPTH; a++) begin
        trc_sel_i = 1'(p); trc_addr_i = AW'(a);
        @(posedge clk); @(negedge clk);
        chk(trc_data_o == tr_exp[p][a],
            $sformatf("R8 R10 entry ph%0d a%0d%s", p, a, (a == 0) ? " R9 kept" : ""),
            longint'(trc_data_o), longint'(tr_exp[p][a]));
      end
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule